// File: doc/BRIEF.md
# Fractional Pulse-Swallow Frequency Divider

This block is the feedback divider of a fractional-N frequency synthesizer loop, written as a synthesizable model. A fast input clock stands in for the oscillator. The block counts its cycles and emits one single-cycle pulse per divide period, which a phase detector can compare against a divided reference.

Each period is built from P prescaler cycles. The first S of them last 33 input cycles and the rest last 32. A modulo-6 accumulator adds a numerator M at every period boundary. Each time the accumulator wraps, the next period is stretched by one input cycle, so the long-run mean ratio is exactly 32·P + S + M/6.

A separate programmable counter divides a reference clock by R. Settings are taken only at period boundaries. Illegal settings are flagged and ignored. A power-down input clears all counting state and silences both outputs.

Top module: `frac_swallow_div`

## Requirements
- R1: With M = 0, the distance between successive `div_pulse` assertions is exactly 32·P + S `vco_clk` cycles. The first S prescaler cycles of a period last 33 input cycles and the remaining P−S last 32.
- R2: At each period boundary, the M of the period just ended is added to a modulo-6 accumulator. If the sum is 6 or more, 6 is subtracted and the next period is one cycle longer. Any 6 consecutive periods under a constant M therefore total 6·(32·P + S) + M cycles. Starting from a cleared accumulator with M = 4 and P = 2, S = 0, periods 2 to 6 are 64, 65, 65, 64, 65 cycles.
- R3: P, S and M are sampled only at the edge that raises `div_pulse` (or the first counting edge after reset or power-down). A period already under way finishes with the old values.
- R4: `cfg_bad` is high, combinationally from the inputs, exactly when S ≥ P, M > 5, P < 2, or R = 0.
- R5: When the divider setting is illegal (S ≥ P, M > 5 or P < 2), the last legal P, S and M stay in force. When R = 0, the last legal R stays in force.
- R6: `ref_pulse` is high for one `ref_clk` cycle every R `ref_clk` cycles. With R = 1 it stays high. A new R is taken when the current reference period ends.
- R7: While `pwr_dn` is high, all counters and the accumulator are cleared and both pulse outputs are low. After release, counting restarts with a fresh period and an empty accumulator.
- R8: `div_pulse` is never high for two consecutive `vco_clk` cycles.
- R9: During reset both pulse outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | Fast clock standing in for the oscillator |
| ref_clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_dn | input | 1 | Power-down, active high |
| p_in | input | 13 | Main count P (2..8191) |
| s_in | input | 6 | Swallow count S (0..63, below P) |
| m_in | input | 3 | Fractional numerator M (0..5) |
| r_in | input | 13 | Reference divide ratio R (1..8191) |
| div_pulse | output | 1 | One-cycle pulse per divide period |
| ref_pulse | output | 1 | One-cycle pulse per reference period |
| cfg_bad | output | 1 | Current inputs contain an illegal setting |

## Verification
A table of P, S and M settings drives the divider:
- Zero-swallow and maximum-swallow settings separate the 33-cycle and 32-cycle prescaler phases.
- Every numerator from 0 to 5 shows whether the six-period total carries exactly M extra cycles.

An exact period sequence after a power-down release pins the accumulator's wrap rule and its one-period lag. A mid-period setting change shows that the running period finishes on the old values. Each kind of illegal setting is applied on top of a known legal one, to show that the old ratio survives. Reference ratios of 1, 5 and 7 and an illegal 0 exercise the reference counter.

// File: rtl/frac_swallow_div.sv
module frac_swallow_div #(
  parameter int PW    = 13,
  parameter int SW    = 6,
  parameter int MW    = 3,
  parameter int RW    = 13,
  parameter int PRE   = 32,
  parameter int FDEN  = 6,
  parameter int DEF_P = 2,
  parameter int DEF_R = 1
) (
  input  logic          vco_clk,
  input  logic          ref_clk,
  input  logic          rst_n,
  input  logic          pwr_dn,
  input  logic [PW-1:0] p_in,
  input  logic [SW-1:0] s_in,
  input  logic [MW-1:0] m_in,
  input  logic [RW-1:0] r_in,
  output logic          div_pulse,
  output logic          ref_pulse,
  output logic          cfg_bad
);
  localparam int CW = $clog2(PRE + 3);

  logic [PW-1:0] p_a, mcnt;
  logic [SW-1:0] s_a;
  logic [MW-1:0] m_a, acc;
  logic [CW-1:0] pcnt, len;
  logic [MW:0]   sum;
  logic [RW-1:0] r_a, rcnt;
  logic          run, stretch, wrap, pre_end, per_end, div_ok, rrun, ref_end;

  assign div_ok  = (p_in >= PW'(2)) && (PW'(s_in) < p_in) &&
                   ({1'b0, m_in} < (MW+1)'(FDEN));
  assign cfg_bad = !div_ok || (r_in == '0);

  assign len     = CW'(PRE) + CW'(mcnt < PW'(s_a)) + CW'(stretch && (mcnt == '0));
  assign pre_end = (pcnt == len - CW'(1));
  assign per_end = pre_end && (mcnt == p_a - PW'(1));
  assign sum     = {1'b0, acc} + {1'b0, m_a};
  assign wrap    = (sum >= (MW+1)'(FDEN));

  always_ff @(posedge vco_clk or negedge rst_n) begin
    if (!rst_n) begin
      p_a <= PW'(DEF_P); s_a <= '0; m_a <= '0;
      run <= 1'b0; pcnt <= '0; mcnt <= '0; acc <= '0;
      stretch <= 1'b0; div_pulse <= 1'b0;
    end else if (pwr_dn) begin
      run <= 1'b0; pcnt <= '0; mcnt <= '0; acc <= '0;
      stretch <= 1'b0; div_pulse <= 1'b0;
    end else if (!run) begin
      run <= 1'b1;
      div_pulse <= 1'b0;
      if (div_ok) begin
        p_a <= p_in; s_a <= s_in; m_a <= m_in;
      end
    end else begin
      div_pulse <= per_end;
      if (pre_end) begin
        pcnt <= '0;
        if (per_end) begin
          mcnt    <= '0;
          acc     <= wrap ? MW'(sum - (MW+1)'(FDEN)) : MW'(sum);
          stretch <= wrap;
          if (div_ok) begin
            p_a <= p_in; s_a <= s_in; m_a <= m_in;
          end
        end else begin
          mcnt <= mcnt + PW'(1);
        end
      end else begin
        pcnt <= pcnt + CW'(1);
      end
    end
  end

  assign ref_end = (rcnt == r_a - RW'(1));

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      r_a <= RW'(DEF_R); rcnt <= '0; rrun <= 1'b0; ref_pulse <= 1'b0;
    end else if (pwr_dn) begin
      rcnt <= '0; rrun <= 1'b0; ref_pulse <= 1'b0;
    end else if (!rrun) begin
      rrun <= 1'b1;
      ref_pulse <= 1'b0;
      if (r_in != '0) r_a <= r_in;
    end else begin
      ref_pulse <= ref_end;
      if (ref_end) begin
        rcnt <= '0;
        if (r_in != '0) r_a <= r_in;
      end else begin
        rcnt <= rcnt + RW'(1);
      end
    end
  end
endmodule

// File: rtl/frac_swallow_div_chk.sv
module frac_swallow_div_chk #(
  parameter int PW   = 13,
  parameter int SW   = 6,
  parameter int MW   = 3,
  parameter int FDEN = 6
) (
  input logic          vco_clk,
  input logic          ref_clk,
  input logic          rst_n,
  input logic          pwr_dn,
  input logic          div_pulse,
  input logic          ref_pulse,
  input logic          run,
  input logic [PW-1:0] p_a,
  input logic [SW-1:0] s_a,
  input logic [MW-1:0] m_a,
  input logic [MW-1:0] acc
);
  a_r8_single_pulse: assert property (@(posedge vco_clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse);

  a_r7_div_quiet: assert property (@(posedge vco_clk) disable iff (!rst_n)
    pwr_dn |=> !div_pulse);

  a_r7_ref_quiet: assert property (@(posedge ref_clk) disable iff (!rst_n)
    pwr_dn |=> !ref_pulse);

  a_r5_active_legal: assert property (@(posedge vco_clk) disable iff (!rst_n)
    (p_a >= PW'(2)) && (PW'(s_a) < p_a) && ({1'b0, m_a} < (MW+1)'(FDEN)));

  a_r2_acc_range: assert property (@(posedge vco_clk) disable iff (!rst_n)
    {1'b0, acc} < (MW+1)'(FDEN));

  a_r3_load_at_edge: assert property (@(posedge vco_clk) disable iff (!rst_n)
    ($past(run) && run && (!$stable(p_a) || !$stable(s_a) || !$stable(m_a)))
      |-> div_pulse);
endmodule

bind frac_swallow_div frac_swallow_div_chk #(.PW(PW), .SW(SW), .MW(MW), .FDEN(FDEN)) u_chk (
  .vco_clk(vco_clk), .ref_clk(ref_clk), .rst_n(rst_n), .pwr_dn(pwr_dn),
  .div_pulse(div_pulse), .ref_pulse(ref_pulse), .run(run),
  .p_a(p_a), .s_a(s_a), .m_a(m_a), .acc(acc));

// File: tb/frac_swallow_div_test.sv
`timescale 1ns/1ps
module frac_swallow_div_test;
  logic vco_clk = 1'b0, ref_clk = 1'b0, rst_n = 1'b0, pwr_dn = 1'b0;
  logic [12:0] p_in = 13'd2, r_in = 13'd4;
  logic [5:0]  s_in = '0;
  logic [2:0]  m_in = '0;
  logic div_pulse, ref_pulse, cfg_bad;

  frac_swallow_div uut (.*);

  always #5 vco_clk = ~vco_clk;
  initial begin #1; forever #7 ref_clk = ~ref_clk; end

  int total = 0, bad = 0;
  int cyc = 0, last_edge = 0, have_last = 0, npulse = 0, last_iv = 0, wide = 0;
  int rcyc = 0, rlast = 0, rhave = 0, rn = 0, r_iv = 0;
  logic prev = 1'b0;

  always @(negedge vco_clk) begin
    cyc++;
    if (pwr_dn) have_last = 0;
    if (div_pulse && prev) wide++;
    if (div_pulse && !prev) begin
      if (have_last != 0) last_iv = cyc - last_edge;
      last_edge = cyc; have_last = 1; npulse++;
    end
    prev = div_pulse;
  end

  always @(negedge ref_clk) begin
    rcyc++;
    if (pwr_dn) rhave = 0;
    else if (ref_pulse) begin
      if (rhave != 0) r_iv = rcyc - rlast;
      rlast = rcyc; rhave = 1; rn++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic next_iv(output int v);
    int n0 = npulse;
    while (npulse == n0) @(posedge vco_clk);
    v = last_iv;
  endtask

  task automatic next_riv(output int v);
    int n0 = rn;
    while (rn == n0) @(posedge ref_clk);
    v = r_iv;
  endtask

  task automatic set_div(input int p, input int s, input int m);
    @(negedge vco_clk);
    p_in = 13'(p); s_in = 6'(s); m_in = 3'(m);
  endtask

  localparam int NV = 7;
  localparam logic [21:0] VEC [NV] = '{
    {13'd2,  6'd0,  3'd0}, {13'd2, 6'd1, 3'd5}, {13'd3, 6'd2, 3'd1},
    {13'd5,  6'd4,  3'd3}, {13'd4, 6'd0, 3'd2}, {13'd8, 6'd7, 3'd0},
    {13'd64, 6'd63, 3'd4}};

  initial begin
    #(10 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v, base, sm, p, s, m;
    int pat [5] = '{0, 1, 1, 0, 1};
    repeat (3) @(negedge vco_clk);
    chk(div_pulse == 1'b0, "R9 div_pulse in reset", int'(div_pulse), 0);
    chk(ref_pulse == 1'b0, "R9 ref_pulse in reset", int'(ref_pulse), 0);
    @(negedge vco_clk); rst_n = 1'b1;

    // R4: flag decode on inputs
    @(negedge vco_clk); #1;
    chk(cfg_bad == 1'b0, "R4 legal setting", int'(cfg_bad), 0);
    s_in = 6'd2; #1;
    chk(cfg_bad == 1'b1, "R4 S>=P", int'(cfg_bad), 1);
    s_in = 6'd0; m_in = 3'd6; #1;
    chk(cfg_bad == 1'b1, "R4 M>5", int'(cfg_bad), 1);
    m_in = 3'd0; p_in = 13'd1; s_in = 6'd0; #1;
    chk(cfg_bad == 1'b1, "R4 P<2", int'(cfg_bad), 1);
    p_in = 13'd2; r_in = 13'd0; #1;
    chk(cfg_bad == 1'b1, "R4 R=0", int'(cfg_bad), 1);
    r_in = 13'd4; #1;
    chk(cfg_bad == 1'b0, "R4 restored", int'(cfg_bad), 0);

    // R1 / R2: vector table
    for (int i = 0; i < NV; i++) begin
      p = int'(VEC[i][21:9]); s = int'(VEC[i][8:3]); m = int'(VEC[i][2:0]);
      set_div(p, s, m);
      base = 32 * p + s;
      next_iv(v); next_iv(v);
      sm = 0;
      for (int k = 0; k < 6; k++) begin
        next_iv(v);
        sm += v;
        chk(v == base || v == base + 1, "R1 period length", v, base);
      end
      chk(sm == 6 * base + m, "R2 six-period total", sm, 6 * base + m);
    end

    // R7 / R2: exact pattern after power-down
    set_div(2, 0, 4);
    @(negedge vco_clk); pwr_dn = 1'b1;
    repeat (3) @(negedge vco_clk);
    for (int k = 0; k < 6; k++) begin
      @(negedge vco_clk);
      chk(div_pulse == 1'b0 && ref_pulse == 1'b0, "R7 outputs low in power-down",
          int'(div_pulse) + int'(ref_pulse), 0);
    end
    pwr_dn = 1'b0;
    next_iv(v);
    for (int k = 0; k < 5; k++) begin
      next_iv(v);
      chk(v == 64 + pat[k], "R2 accumulator pattern", v, 64 + pat[k]);
    end

    // R3: change mid-period
    set_div(2, 0, 0);
    next_iv(v); next_iv(v);
    repeat (20) @(negedge vco_clk);
    p_in = 13'd3;
    next_iv(v);
    chk(v == 64, "R3 running period keeps old P", v, 64);
    next_iv(v);
    chk(v == 96, "R3 new P next period", v, 96);

    // R5: illegal settings keep last legal one
    set_div(3, 1, 0);
    next_iv(v); next_iv(v);
    set_div(3, 3, 0);
    #1 chk(cfg_bad == 1'b1, "R5 flag for S>=P", int'(cfg_bad), 1);
    next_iv(v); next_iv(v);
    chk(v == 97, "R5 held on S>=P", v, 97);
    set_div(4, 0, 6);
    next_iv(v); next_iv(v);
    chk(v == 97, "R5 held on M>5", v, 97);
    set_div(1, 0, 0);
    next_iv(v); next_iv(v);
    chk(v == 97, "R5 held on P<2", v, 97);
    set_div(2, 0, 0);

    // R6: reference counter
    @(negedge ref_clk); r_in = 13'd5;
    next_riv(v); next_riv(v); next_riv(v);
    chk(v == 5, "R6 R=5", v, 5);
    next_riv(v);
    chk(v == 5, "R6 R=5 repeat", v, 5);
    @(negedge ref_clk); r_in = 13'd1;
    next_riv(v); next_riv(v); next_riv(v);
    chk(v == 1, "R6 R=1", v, 1);
    @(negedge ref_clk); r_in = 13'd7;
    next_riv(v); next_riv(v); next_riv(v);
    chk(v == 7, "R6 R=7", v, 7);
    @(negedge ref_clk); r_in = 13'd0;
    next_riv(v); next_riv(v); next_riv(v);
    chk(v == 7, "R5 R=0 holds last R", v, 7);
    @(negedge ref_clk); r_in = 13'd4;

    chk(wide == 0, "R8 pulse width one cycle", wide, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule